// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits on the transmit path of a network interface. For each outgoing frame it first takes a five-word control header on a 32-bit sideband stream and then the frame itself on a byte stream. It stores the whole frame in internal memory. While the bytes arrive, it builds a ones'-complement sum over the part of the frame that starts at a per-frame start offset.

When the frame is complete and the header asks for offload, the block adds the seed from the header to the sum. It folds the result to 16 bits, complements it, and overwrites two bytes of the stored frame at a per-frame insert offset. The frame then goes out on the byte output stream, and a one-cycle done pulse follows the last byte.

Three static configuration inputs gate transmission. One enables transmission as a whole. The other two are a jumbo allowance and a tagged-frame allowance. Together they decide whether frames a few bytes over the standard maximum are sent or discarded.

Top module: `txcs_inserter`

## Requirements
- R1: While reset is held and directly after it, ctl_ready is 1 and in_ready, out_valid and tx_done are 0.
- R2: The header is exactly five 32-bit words. In word 0, bit 0 enables insertion. Word 1 holds the start offset in bits 31:16 and the insert offset in bits 15:0. Word 2 holds the seed in bits 15:0. All other header bits, and words 3 and 4, have no effect. in_ready stays 0 until the fifth word has been accepted.
- R3: The checksum takes the bytes from the start offset up to the frame end as big-endian 16-bit words, with an odd last byte padded by a zero low byte. The seed is added to this sum. The total is folded to 16 bits with end-around carry, and the folded value is complemented.
- R4: With insertion enabled, the upper checksum byte replaces the byte at the insert offset and the lower byte replaces the one after it. Every other byte leaves unchanged.
- R5: With header bit 0 clear, the frame is forwarded byte for byte unchanged.
- R6: If the insert offset plus one is not below the frame length, no byte is replaced.
- R7: A start offset at or beyond the frame end gives the complemented fold of the seed alone.
- R8: If tx_enable is 0 when the frame ends, the frame is consumed without output and without tx_done, and the next header is accepted.
- R9: With jumbo_en and vlan_en both 0, frames of 1519 to 1522 bytes are discarded. Setting either input admits them. Lengths outside that band are never discarded for size.
- R10: The output frame has the input length and out_last is set on its final byte only. While out_valid is 1 and out_ready is 0, out_data and out_last hold.
- R11: tx_done is a one-cycle pulse in the cycle after the final output byte is accepted.
- R12: Output starts only after the whole input frame has been received. While out_valid is 1, neither input stream is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmission enable, sampled at frame end |
| jumbo_en | input | 1 | Allow frames above the standard maximum |
| vlan_en | input | 1 | Allow tagged-size frames (up to 4 bytes over) |
| ctl_valid | input | 1 | Header word valid |
| ctl_ready | output | 1 | Header word accepted |
| ctl_data | input | 32 | Header word |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte |
| tx_done | output | 1 | Frame-sent pulse |

## Verification
The assertions take for granted that every frame ends with in_last, that no frame is longer than MAX_BYTES, and that the configuration inputs stay steady while a frame ends. The stimulus sends each frame only after the header handshake completes. Frames are kept between 16 and 1523 bytes, and tx_enable, jumbo_en and vlan_en change only while the block waits for a header. The downstream side toggles out_ready on some frames, so that held output is exercised under the stall rule.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
  typedef enum logic [1:0] {
    ST_HDR    = 2'd0,
    ST_DATA   = 2'd1,
    ST_DECIDE = 2'd2,
    ST_SEND   = 2'd3
  } txcs_state_e;

  // Add seed, fold twice with end-around carry, complement.
  function automatic logic [15:0] finish_csum(input logic [31:0] acc,
                                              input logic [15:0] seed);
    logic [31:0] s;
    logic [16:0] t;
    logic [15:0] u;
    s = acc + {16'b0, seed};
    t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    u = t[15:0] + {15'b0, t[16]};
    return ~u;
  endfunction
endpackage

// File: rtl/txcs_hdr.sv
module txcs_hdr #(
  parameter int HDR_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [31:0] word,
  output logic        ins_en,
  output logic [15:0] start_off,
  output logic [15:0] wr_off,
  output logic [15:0] seed,
  output logic        hdr_done
);
  localparam int IW = $clog2(HDR_WORDS);

  logic [IW-1:0] idx_q, idx_d;
  logic          en_d;
  logic [15:0]   start_d, wr_d, seed_d;

  assign hdr_done = take && (idx_q == IW'(HDR_WORDS - 1));

  always_comb begin
    idx_d   = idx_q;
    en_d    = ins_en;
    start_d = start_off;
    wr_d    = wr_off;
    seed_d  = seed;
    if (take) begin
      idx_d = hdr_done ? '0 : idx_q + IW'(1);
      if (idx_q == IW'(0)) en_d = word[0];
      if (idx_q == IW'(1)) begin
        start_d = word[31:16];
        wr_d    = word[15:0];
      end
      if (idx_q == IW'(2)) seed_d = word[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      ins_en    <= 1'b0;
      start_off <= '0;
      wr_off    <= '0;
      seed      <= '0;
    end else if (take) begin
      idx_q     <= idx_d;
      ins_en    <= en_d;
      start_off <= start_d;
      wr_off    <= wr_d;
      seed      <= seed_d;
    end
  end
endmodule

// File: rtl/txcs_sum.sv
module txcs_sum #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [7:0]       data,
  input  logic [LEN_W-1:0] pos,
  input  logic [15:0]      start,
  output logic [31:0]      acc
);
  logic [31:0] acc_d;
  logic        in_range, low_half;

  assign in_range = (16'(pos) >= start);
  assign low_half = pos[0] ^ start[0];

  always_comb begin
    acc_d = acc;
    if (clear)
      acc_d = '0;
    else if (add_en && in_range)
      acc_d = acc + (low_half ? {24'b0, data} : {16'b0, data, 8'b0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc <= '0;
    else if (clear || add_en) acc <= acc_d;
  end
endmodule

// File: rtl/txcs_buf.sv
module txcs_buf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/txcs_inserter.sv
module txcs_inserter
  import txcs_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  parameter int STD_FRAME = 1518,
  parameter int TAG_BYTES = 4,
  parameter int HDR_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_enable,
  input  logic        jumbo_en,
  input  logic        vlan_en,
  input  logic        ctl_valid,
  output logic        ctl_ready,
  input  logic [31:0] ctl_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        tx_done
);
  localparam int AW    = $clog2(MAX_BYTES);
  localparam int LEN_W = AW + 1;
  localparam logic [LEN_W-1:0] BAND_LO = LEN_W'(STD_FRAME + 1);
  localparam logic [LEN_W-1:0] BAND_HI = LEN_W'(STD_FRAME + TAG_BYTES);

  txcs_state_e      state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d, rd_q, rd_d;
  logic [15:0]      csum_q, csum_d;
  logic             done_d;

  logic        ins_en, hdr_done, in_take, drop, ins_ok, is_last;
  logic [15:0] start_off, wr_off, seed, rd_ext;
  logic [31:0] acc;
  logic [7:0]  mem_q;

  assign ctl_ready = (state_q == ST_HDR);
  assign in_ready  = (state_q == ST_DATA);
  assign out_valid = (state_q == ST_SEND);
  assign in_take   = in_valid && in_ready;

  txcs_hdr #(.HDR_WORDS(HDR_WORDS)) u_hdr (
    .clk(clk), .rst_n(rst_n), .take(ctl_valid && ctl_ready), .word(ctl_data),
    .ins_en(ins_en), .start_off(start_off), .wr_off(wr_off), .seed(seed),
    .hdr_done(hdr_done)
  );

  txcs_sum #(.LEN_W(LEN_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clear(hdr_done), .add_en(in_take),
    .data(in_data), .pos(cnt_q), .start(start_off), .acc(acc)
  );

  txcs_buf #(.DEPTH(MAX_BYTES), .AW(AW)) u_buf (
    .clk(clk), .wr_en(in_take && (cnt_q < LEN_W'(MAX_BYTES))),
    .wr_addr(cnt_q[AW-1:0]), .wr_data(in_data),
    .rd_addr(rd_q[AW-1:0]), .rd_data(mem_q)
  );

  // Size band and enable gating, evaluated once the length is known.
  assign drop = !tx_enable ||
                (!jumbo_en && !vlan_en && len_q >= BAND_LO && len_q <= BAND_HI);
  assign ins_ok  = ins_en && (({1'b0, wr_off} + 17'd1) < 17'(len_q));
  assign rd_ext  = 16'(rd_q);
  assign is_last = (rd_q == len_q - LEN_W'(1));
  assign out_last = out_valid && is_last;

  always_comb begin
    out_data = mem_q;
    if (ins_ok && rd_ext == wr_off)               out_data = csum_q[15:8];
    if (ins_ok && rd_ext == wr_off + 16'd1)       out_data = csum_q[7:0];
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    rd_d    = rd_q;
    csum_d  = csum_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_HDR: if (hdr_done) begin
        state_d = ST_DATA;
        cnt_d   = '0;
      end
      ST_DATA: if (in_take) begin
        cnt_d = cnt_q + LEN_W'(1);
        if (in_last) begin
          len_d   = cnt_q + LEN_W'(1);
          state_d = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        csum_d  = finish_csum(acc, seed);
        rd_d    = '0;
        state_d = drop ? ST_HDR : ST_SEND;
      end
      ST_SEND: if (out_ready) begin
        rd_d = rd_q + LEN_W'(1);
        if (is_last) begin
          state_d = ST_HDR;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      len_q   <= '0;
      rd_q    <= '0;
      csum_q  <= '0;
      tx_done <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      rd_q    <= rd_d;
      csum_q  <= csum_d;
      tx_done <= done_d;
    end
  end
endmodule

// File: rtl/txcs_chk.sv
module txcs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_ready,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       tx_done
);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R11
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(out_valid && out_ready && out_last));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R12
  no_input_while_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!in_ready && !ctl_ready));

  // R10
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind txcs_inserter txcs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .tx_done(tx_done)
);

// File: tb/sim_txcs_inserter.sv
module sim_txcs_inserter;
  logic clk = 1'b0;
  logic rst_n;
  logic tx_enable, jumbo_en, vlan_en;
  logic ctl_valid, ctl_ready;
  logic [31:0] ctl_data;
  logic in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic out_valid, out_ready, out_last, tx_done;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;

  logic [7:0] frame [0:2047];
  logic [7:0] expd  [0:2047];

  always #5 clk = ~clk;

  txcs_inserter u0 (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .jumbo_en(jumbo_en),
    .vlan_en(vlan_en), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .ctl_data(ctl_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .tx_done(tx_done)
  );

  // {en, backpressure, len[12], start[16], insert[16], seed[16]}
  localparam logic [61:0] VECS [0:6] = '{
    {1'b1, 1'b0, 12'd20, 16'd14, 16'd16, 16'h0000},  // R3 R4 even span
    {1'b1, 1'b0, 12'd21, 16'd14, 16'd18, 16'h1234},  // R3 odd tail pad
    {1'b1, 1'b1, 12'd60, 16'd0,  16'd0,  16'hffff},  // R3 seed carry, R10 stall
    {1'b0, 1'b0, 12'd30, 16'd2,  16'd4,  16'h5555},  // R5 pass-through
    {1'b1, 1'b0, 12'd24, 16'd0,  16'd23, 16'h0101},  // R6 offset at end
    {1'b1, 1'b0, 12'd16, 16'd20, 16'd2,  16'hbeef},  // R7 start past end
    {1'b1, 1'b1, 12'd64, 16'd34, 16'd40, 16'habcd}   // R4 R10 stalls
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_csum(input int len, input int start,
                                           input logic [15:0] seed);
    longint s = seed;
    for (int i = start; i < len; i += 2) begin
      longint hi = frame[i];
      longint lo = (i + 1 < len) ? frame[i+1] : 0;
      s += hi * 256 + lo;
    end
    while (s >> 16 != 0) s = (s & 64'hffff) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_data = w;
    while (!ctl_ready) @(negedge clk);
    @(posedge clk); #1;
    ctl_valid = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_frame(input int k, input int len, input int start,
                           input int wr, input logic [15:0] seed, input bit en,
                           input bit bp, input bit exp_drop, input string rq);
    logic [15:0] cs;
    int got = 0, bad_at = -1, to = 0;
    logic [7:0] bad_act = 0, bad_exp = 0;
    bit seen_last = 0, early = 0, odd = 0;
    for (int i = 0; i < len; i++)
      frame[i] = 8'((i * 13 + k * 29 + 7) ^ (i >> 3));
    // R2: upper bits of word 0, upper half of word 2 and words 3-4 carry junk.
    push_word({31'h52A5_A5A4, en});
    push_word({16'(start), 16'(wr)});
    push_word({16'hDEAD, seed});
    push_word(32'hFFFF_FFFF);
    @(negedge clk);
    check(!in_ready, "R2", "in_ready before fifth word", in_ready, 0);
    push_word(32'h0123_4567);
    for (int i = 0; i < len; i++) push_byte(frame[i], i == len - 1);
    cs = ref_csum(len, start, seed);
    for (int i = 0; i < len; i++) expd[i] = frame[i];
    if (en && wr + 1 < len) begin
      expd[wr] = cs[15:8]; expd[wr+1] = cs[7:0];
    end
    if (exp_drop) begin
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (out_valid || tx_done) odd = 1;
      end
      check(!odd, rq, "dropped frame produced output", odd, 0);
      check(ctl_ready, rq, "ready for next header after drop", ctl_ready, 1);
      return;
    end
    while (!seen_last && to < 20000) begin
      @(negedge clk);
      out_ready = bp ? ~out_ready : 1'b1;
      if (tx_done) early = 1;
      if (out_valid && out_ready) begin
        if (out_data !== expd[got] && bad_at < 0) begin
          bad_at = got; bad_act = out_data; bad_exp = expd[got];
        end
        if (out_last) seen_last = 1;
        else if (got == len - 1) early = 1;
        got++;
      end
      to++;
    end
    out_ready = 1'b1;
    check(bad_at < 0, rq, $sformatf("frame %0d byte %0d", k, bad_at), bad_act, bad_exp);
    check(seen_last && got == len && !early, "R10", "output length/last", got, len);
    @(negedge clk);
    check(tx_done === 1'b1, "R11", "tx_done after last byte", tx_done, 1);
    @(negedge clk);
    check(tx_done === 1'b0, "R11", "tx_done one cycle", tx_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_enable = 1'b1; jumbo_en = 1'b0; vlan_en = 1'b0;
    ctl_valid = 1'b0; ctl_data = '0; in_valid = 1'b0; in_data = '0;
    in_last = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctl_ready === 1'b1, "R1", "ctl_ready in reset", ctl_ready, 1);
    check(!in_ready && !out_valid && !tx_done, "R1", "idle outputs in reset",
          {in_ready, out_valid, tx_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctl_ready && !in_ready && !out_valid && !tx_done, "R1", "after release",
          {ctl_ready, in_ready, out_valid, tx_done}, 4'b1000);

    // Vector table: R3 R4 R5 R6 R7 R10 R11 R12
    for (int k = 0; k < 7; k++) begin
      logic [61:0] v = VECS[k];
      run_frame(k, int'(v[59:48]), int'(v[47:32]), int'(v[31:16]), v[15:0],
                v[61], v[60], 1'b0, "R3/R4/R5/R6/R7");
    end

    // R8: transmission disabled drops the frame.
    tx_enable = 1'b0;
    run_frame(10, 20, 14, 16, 16'h0, 1'b1, 1'b0, 1'b1, "R8");
    tx_enable = 1'b1;
    run_frame(11, 22, 0, 4, 16'h7, 1'b1, 1'b0, 1'b0, "R8 recovery");

    // R9: size band gating.
    run_frame(12, 1520, 14, 30, 16'h1, 1'b1, 1'b0, 1'b1, "R9 band drop");
    run_frame(13, 1519, 14, 30, 16'h2, 1'b1, 1'b0, 1'b1, "R9 band low edge");
    vlan_en = 1'b1;
    run_frame(14, 1522, 14, 1520, 16'h3, 1'b1, 1'b0, 1'b0, "R9 tagged allowed");
    vlan_en = 1'b0; jumbo_en = 1'b1;
    run_frame(15, 1521, 0, 100, 16'h4, 1'b1, 1'b0, 1'b0, "R9 jumbo allowed");
    jumbo_en = 1'b0;
    run_frame(16, 1523, 14, 50, 16'h5, 1'b1, 1'b0, 1'b0, "R9 above band");
    run_frame(17, 1518, 14, 50, 16'h6, 1'b1, 1'b0, 1'b0, "R9 below band");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule